// File: doc/BRIEF.md
# Decimal-to-BCD Priority Encoder

This block turns nine decimal digit request lines into a four-bit BCD code. Each request line stands for one of the digits 1 through 9 and is active LOW. When more than one line is pulled low, the code for the largest digit wins. Zero has no line of its own: when every digit line is idle, the encoder reports zero. The code leaves the block active LOW, so the pins carry the bitwise complement of the BCD value.

In a keypad front end the block also watches a separate active-LOW line for the zero key. That line never changes the code. It only takes part in a key-detect flag, which rises whenever any key from 0 to 9 is held. The block is purely combinational. Debounce and key scanning are left to other logic. No stream interface is involved: every pin is a plain level signal and the outputs follow the inputs without a clock.

Top module: `dec_prio_encoder`

## Requirements
- R1: With all nine digit lines HIGH, bcd_n is 4'b1111, the complement of BCD 0.
- R2: With exactly one digit line low, bcd_n is the complement of that digit's value. digit_n bit i stands for decimal digit i+1.
- R3: With several digit lines low, bcd_n is the complement of the highest-valued active digit. For example, digits 3 and 7 together give 4'b1000.
- R4: key_hit is HIGH exactly when at least one of digit_n or zero_key_n is LOW.
- R5: zero_key_n has no effect on bcd_n.
- R6: The complement of bcd_n is never above 9.
- R7: When the line for digit 9 (bit 8) is low, bcd_n is 4'b0110, whatever the other lines do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digit_n | input | 9 | Active-LOW request lines; bit i is decimal digit i+1 |
| zero_key_n | input | 1 | Active-LOW zero-key line; used only for key detection |
| bcd_n | output | 4 | Active-LOW BCD code of the highest active digit |
| key_hit | output | 1 | Active-HIGH flag: some key from 0 to 9 is held |

## Verification
All 512 digit patterns are compared against an independent model that searches from the highest digit downward. This catches a resolver that favours the lowest digit, which would report 3 instead of 7 for the pair. The idle pattern and the all-low pattern probe the two extremes. A missing output inversion would show up at once as 0000 for idle. The zero-key line is toggled both with and without digits held. A design that lets that line reach the code, or drops it from key_hit, would disagree on those vectors.

// File: rtl/dec_prio_pkg.sv
package dec_prio_pkg;
  localparam int unsigned DIGITS = 9;
  localparam int unsigned CODE_W = $clog2(DIGITS + 1);
  typedef logic [DIGITS-1:0] digit_vec_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/dpe_sense.sv
module dpe_sense #(
  parameter int unsigned WIDTH      = 9,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] act_o
);
  // per-line polarity normalisation to active-high
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    if (ACTIVE_LOW) begin : g_inv
      assign act_o[g] = ~pin_i[g];
    end else begin : g_pass
      assign act_o[g] = pin_i[g];
    end
  end
endmodule

// File: rtl/dpe_resolve.sv
module dpe_resolve #(
  parameter int unsigned WIDTH  = 9,
  parameter int unsigned CODE_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0]  act_i,
  output logic [CODE_W-1:0] value_o
);
  // ascending scan: a later (higher) active line overwrites earlier ones
  always_comb begin
    value_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (act_i[i]) value_o = CODE_W'(i + 1);
    end
  end

  always_comb begin
    if (!$isunknown(act_i) && (act_i != '0)) begin
      // R3: the winning line is itself active
      a_r3_winner_active: assert (act_i[value_o - 1'b1]);
      // R3: nothing above the winner is active
      a_r3_none_above: assert ((act_i >> value_o) == '0);
    end
    if (!$isunknown(act_i) && (act_i == '0)) begin
      a_r1_idle_zero: assert (value_o == '0);
    end
  end
endmodule

// File: rtl/dpe_drive.sv
module dpe_drive #(
  parameter int unsigned CODE_W     = 4,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input  logic [CODE_W-1:0] value_i,
  output logic [CODE_W-1:0] pin_o
);
  for (genvar g = 0; g < CODE_W; g++) begin : g_bit
    if (ACTIVE_LOW) begin : g_inv
      assign pin_o[g] = ~value_i[g];
    end else begin : g_pass
      assign pin_o[g] = value_i[g];
    end
  end
endmodule

// File: rtl/dec_prio_encoder.sv
module dec_prio_encoder
  import dec_prio_pkg::*;
(
  input  logic [8:0] digit_n,
  input  logic       zero_key_n,
  output logic [3:0] bcd_n,
  output logic       key_hit
);
  digit_vec_t act;
  code_t      value;

  dpe_sense #(.WIDTH(DIGITS), .ACTIVE_LOW(1'b1)) u_sense (
    .pin_i (digit_n),
    .act_o (act)
  );

  dpe_resolve #(.WIDTH(DIGITS), .CODE_W(CODE_W)) u_resolve (
    .act_i   (act),
    .value_o (value)
  );

  dpe_drive #(.CODE_W(CODE_W), .ACTIVE_LOW(1'b1)) u_drive (
    .value_i (value),
    .pin_o   (bcd_n)
  );

  assign key_hit = (|act) | ~zero_key_n;

  always_comb begin
    if (!$isunknown({digit_n, zero_key_n})) begin
      a_r1_idle_code: assert (!(&digit_n) || (bcd_n == 4'b1111));
      a_r4_hit_has_key: assert (!key_hit || !(&{digit_n, zero_key_n}));
      a_r6_in_range: assert ((~bcd_n) <= 4'd9);
      a_r7_nine_wins: assert (digit_n[8] || (bcd_n == 4'b0110));
    end
  end
endmodule

// File: tb/test_dec_prio_encoder.sv
module test_dec_prio_encoder;
  logic       clk = 1'b0;
  logic [8:0] digit_n = 9'h1FF;
  logic       zero_key_n = 1'b1;
  logic [3:0] bcd_n;
  logic       key_hit;
  int         n_run = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  dec_prio_encoder i_dec_prio_encoder (
    .digit_n    (digit_n),
    .zero_key_n (zero_key_n),
    .bcd_n      (bcd_n),
    .key_hit    (key_hit)
  );

  // {digit_n, zero_key_n, expected bcd_n, expected key_hit}
  localparam logic [14:0] VEC [9] = '{
    {9'h1FF, 1'b1, 4'hF, 1'b0},  // R1 idle
    {9'h1FF, 1'b0, 4'hF, 1'b1},  // R5/R4 zero key only
    {9'h1FE, 1'b1, 4'hE, 1'b1},  // R2 digit 1
    {9'h1BB, 1'b1, 4'h8, 1'b1},  // R3 digits 3 and 7
    {9'h0FF, 1'b1, 4'h6, 1'b1},  // R7 digit 9
    {9'h000, 1'b0, 4'h6, 1'b1},  // R7 all low
    {9'h17F, 1'b1, 4'h7, 1'b1},  // R2 digit 8
    {9'h1E5, 1'b1, 4'hA, 1'b1},  // R3 digits 2,4,5
    {9'h1FE, 1'b0, 4'hE, 1'b1}   // R5 digit 1 with zero key
  };

  function automatic logic [3:0] ref_code(input logic [8:0] d);
    for (int k = 9; k >= 1; k--) begin
      if (d[k-1] == 1'b0) return ~4'(k);
    end
    return 4'b1111;
  endfunction

  task automatic check(input string req, input logic [3:0] exp_code, input logic exp_hit);
    n_run++;
    if (bcd_n !== exp_code || key_hit !== exp_hit) begin
      n_fail++;
      $display("FAIL %s: digit_n=%b zero_key_n=%b got bcd_n=%b key_hit=%b exp bcd_n=%b key_hit=%b",
               req, digit_n, zero_key_n, bcd_n, key_hit, exp_code, exp_hit);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    check("R1 reset idle", 4'hF, 1'b0);

    for (int v = 0; v < 9; v++) begin
      @(posedge clk);
      digit_n    = VEC[v][14:6];
      zero_key_n = VEC[v][5];
      @(negedge clk);
      check("R1-R7 table", VEC[v][4:1], VEC[v][0]);
    end

    // exhaustive sweep: R2 R3 R4 R6 R7, with zero key both ways for R5
    for (int z = 0; z < 2; z++) begin
      for (int p = 0; p < 512; p++) begin
        @(posedge clk);
        digit_n    = 9'(p);
        zero_key_n = z[0];
        @(negedge clk);
        check("R3 sweep", ref_code(9'(p)), (p != 511) || (z == 0));
        n_run++;
        if ((~bcd_n) > 4'd9) begin
          n_fail++;
          $display("FAIL R6: bcd_n=%b exp complement <= 9", bcd_n);
        end
      end
    end

    // R2 single-line walk
    for (int k = 1; k <= 9; k++) begin
      @(posedge clk);
      digit_n    = ~(9'd1 << (k - 1));
      zero_key_n = 1'b1;
      @(negedge clk);
      check("R2 single", ~4'(k), 1'b1);
    end

    // R5: toggling zero key with digit 6 held keeps code
    @(posedge clk);
    digit_n = ~9'h020; zero_key_n = 1'b0;
    @(negedge clk);
    check("R5 zero key held", 4'h9, 1'b1);
    @(posedge clk);
    zero_key_n = 1'b1;
    @(negedge clk);
    check("R5 zero key released", 4'h9, 1'b1);

    // R4 back to idle clears flag
    @(posedge clk);
    digit_n = 9'h1FF;
    @(negedge clk);
    check("R4 idle clears", 4'hF, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule